// File: doc/BRIEF.md
# Multi-channel comparator event timer

The block is a memory-mapped event timer. It has one free-running 64-bit up-counter and a parameterized number of comparator channels (3 to 8). Software programs each channel with a match value and, when the channel runs in periodic mode, with a reload period. When the counter reaches the match value exactly, the channel raises an interrupt. That interrupt is either a one-cycle edge pulse or a level that stays high until software clears it. A channel can instead emit a message strobe that carries a data word and an address word held in its route registers. In a legacy-routing mode, channels 0 and 1 drive two dedicated legacy interrupt outputs.

Register access goes through a simple 32-bit word port. Writes are synchronous and reads are combinational on the word address. The block deliberately keeps three properties that drivers must plan around. A match is exact equality only. A comparator write reaches the match logic only after a fixed pipeline delay. A one-shot set-value bit decides whether a comparator write loads the match value or the period.

Top module: `evt_timer`

## Requirements
- R1: Word 0x00 reads the capability word: bits [12:8] hold the channel count minus one and bit 15 reads 1 to show that legacy routing is present; all other bits read 0. Word 0x01 reads the tick period in femtoseconds (parameter PERIOD_FS). Writes to either word have no effect.
- R2: After reset the counter, the general control word (0x02) and the status word (0x03) read 0, every comparator half reads 0xFFFFFFFF, every period is 0, and all interrupt and strobe outputs are low.
- R3: The counter advances by one per clock only while control bit 0 is 1. While the bit is 0, the counter holds its value.
- R4: Words 0x04 and 0x05 read and write the low and high 32-bit halves of the counter. A write replaces that half at the next edge, and the write takes priority over counting.
- R5: Channel c uses words 0x08+8c+k, where k=0 is configuration, 1 is the comparator low half, 2 the comparator high half, 3 the route data word and 4 the route address word. A match requires the running counter to equal the comparator exactly. A comparator value below the counter never fires.
- R6: Configuration bit 3 selects periodic mode and bit 6 is the set-value bit. In periodic mode, a comparator write made while bit 6 is 1 loads the match value, and a write made while bit 6 is 0 loads the period. A write to the low half clears bit 6 by itself. On every match, the period is added to the match value.
- R7: With configuration bit 5 set, the channel compares, and accumulates the period into, only the low 32 bits of the counter and comparator.
- R8: Bit 2 enables the interrupt. With bit 1 clear, a match gives a one-cycle pulse on irq_o[c] in the cycle after the edge where the counter equaled the comparator. With bit 1 set, a match sets status bit c, which stays set until 1 is written to it, and irq_o[c] equals status bit c AND bit 2.
- R9: With configuration bit 7 and bit 2 both set, a match gives a one-cycle msg_stb_o[c] pulse, msg_data_o and msg_addr_o carry the channel's route words, and irq_o[c] stays low.
- R10: With control bit 1 set, the interrupts of channels 0 and 1 appear on leg_irq_o[0] and leg_irq_o[1], and irq_o[0] and irq_o[1] stay low.
- R11: A comparator write reaches the match logic, and becomes visible on read, at the CMP_DLY-th clock edge after the write edge. Until then, a read returns the previous value.
- R12: Configuration bit 4 reads 1 when the channel supports periodic mode and bit 8 always reads 1 (message delivery supported). Channel 1 is built without periodic support by default, so its bit 4 reads 0 and bit 3 cannot be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | N_CH | Per-channel interrupt lines |
| leg_irq_o | output | 2 | Legacy interrupt lines for channels 0 and 1 |
| msg_stb_o | output | N_CH | Per-channel message strobes |
| msg_data_o | output | N_CH*32 | Route data word of each channel |
| msg_addr_o | output | N_CH*32 | Route address word of each channel |

## Verification
A wrong comparator or period shows up at the pins as an interrupt pulse in the wrong cycle. To catch this, the bench records the counter value in the same sample as each pulse, so an off-by-one in the match, the reload or the pipeline delay is seen as a counter value off by one at the first event. A set-value bit that fails to clear turns the period write into a second match write. This shows up at the first reload as a missing or mistimed second pulse. The read-back of a comparator in the two cycles after a write exposes a wrong delay depth within two clocks.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [7:0] REG_ID   = 8'h00;
  localparam logic [7:0] REG_PER  = 8'h01;
  localparam logic [7:0] REG_GCFG = 8'h02;
  localparam logic [7:0] REG_STS  = 8'h03;
  localparam logic [7:0] REG_CLO  = 8'h04;
  localparam logic [7:0] REG_CHI  = 8'h05;

  localparam logic [2:0] CH_CFG  = 3'd0;
  localparam logic [2:0] CH_CMPL = 3'd1;
  localparam logic [2:0] CH_CMPH = 3'd2;
  localparam logic [2:0] CH_RDAT = 3'd3;
  localparam logic [2:0] CH_RADR = 3'd4;

  typedef struct packed {
    logic        hi;
    logic        to_per;
    logic [31:0] data;
  } cmp_wr_t;

  typedef struct packed {
    logic msg_en;
    logic setval;
    logic m32;
    logic per;
    logic en;
    logic level;
  } ch_cfg_t;
endpackage

// File: rtl/evt_main_cnt.sv
module evt_main_cnt #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_lo_i) cnt_q[HALF_W-1:0] <= wdata_i;
    else if (wr_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
    else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
  AST_CNT_WR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_q[HALF_W-1:0] == $past(wdata_i)); // R4
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int CMP_DLY = 2,
  parameter bit PER_CAP = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] cnt_i,
  input  logic        cnt_run_i,
  input  logic        wr_i,
  input  logic [2:0]  reg_i,
  input  logic [31:0] wdata_i,
  input  logic        sts_clr_i,
  output logic [31:0] cfg_o,
  output logic [63:0] cmp_o,
  output logic [31:0] rdat_o,
  output logic [31:0] radr_o,
  output logic        sts_o,
  output logic        irq_line_o,
  output logic        msg_stb_o
);
  ch_cfg_t              cfg_q;
  logic    [63:0]       cmp_q, per_q;
  logic    [31:0]       rdat_q, radr_q;
  logic                 sts_q, pulse_q, msg_q;
  cmp_wr_t              pipe_q [CMP_DLY];
  logic    [CMP_DLY-1:0] vld_q;

  logic    cmp_wr, hit, app_v;
  cmp_wr_t app;

  assign cmp_wr = wr_i && (reg_i == CH_CMPL || reg_i == CH_CMPH);
  assign app    = pipe_q[CMP_DLY-1];
  assign app_v  = vld_q[CMP_DLY-1];
  assign hit    = cnt_run_i && (cfg_q.m32 ? (cnt_i[31:0] == cmp_q[31:0]) : (cnt_i == cmp_q));

  // comparator write delay line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < CMP_DLY; i++) pipe_q[i] <= '0;
    end else begin
      vld_q[0]  <= cmp_wr;
      pipe_q[0] <= '{hi: (reg_i == CH_CMPH), to_per: (cfg_q.per && !cfg_q.setval), data: wdata_i};
      for (int i = 1; i < CMP_DLY; i++) begin
        vld_q[i]  <= vld_q[i-1];
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      rdat_q <= '0;
      radr_q <= '0;
    end else if (wr_i) begin
      case (reg_i)
        CH_CFG: cfg_q <= '{msg_en: wdata_i[7], setval: wdata_i[6], m32: wdata_i[5],
                           per: wdata_i[3] & PER_CAP, en: wdata_i[2], level: wdata_i[1]};
        CH_CMPL: if (cfg_q.setval) cfg_q.setval <= 1'b0;
        CH_RDAT: rdat_q <= wdata_i;
        CH_RADR: radr_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      if (hit && cfg_q.per) begin
        if (cfg_q.m32) cmp_q[31:0] <= cmp_q[31:0] + per_q[31:0];
        else           cmp_q       <= cmp_q + per_q;
      end
      if (app_v) begin
        if (app.to_per) begin
          if (app.hi) per_q[63:32] <= app.data;
          else        per_q[31:0]  <= app.data;
        end else begin
          if (app.hi) cmp_q[63:32] <= app.data;
          else        cmp_q[31:0]  <= app.data;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      if (hit && cfg_q.level)  sts_q <= 1'b1;
      else if (sts_clr_i)      sts_q <= 1'b0;
      pulse_q <= hit && cfg_q.en && !cfg_q.level && !cfg_q.msg_en;
      msg_q   <= hit && cfg_q.en && cfg_q.msg_en;
    end
  end

  assign cfg_o      = {23'd0, 1'b1, cfg_q.msg_en, cfg_q.setval, cfg_q.m32, PER_CAP,
                       cfg_q.per, cfg_q.en, cfg_q.level, 1'b0};
  assign cmp_o      = cmp_q;
  assign rdat_o     = rdat_q;
  assign radr_o     = radr_q;
  assign sts_o      = sts_q;
  assign msg_stb_o  = msg_q;
  assign irq_line_o = cfg_q.msg_en ? 1'b0 : (cfg_q.level ? (sts_q && cfg_q.en) : pulse_q);

  AST_SETVAL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_i == CH_CMPL && cfg_q.setval) |=> !cfg_q.setval); // R6
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!app_v && !(hit && cfg_q.per)) |=> $stable(cmp_q)); // R11
  AST_LVL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !sts_clr_i) |=> sts_q); // R8
  AST_NO_PER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !PER_CAP |-> !cfg_q.per); // R12
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int          N_CH      = 3,
  parameter int          CMP_DLY   = 2,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  parameter logic [7:0]  PER_CAP   = 8'hFD,
  localparam int         DW        = N_CH * 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic [N_CH-1:0] irq_o,
  output logic [1:0]      leg_irq_o,
  output logic [N_CH-1:0] msg_stb_o,
  output logic [DW-1:0]   msg_data_o,
  output logic [DW-1:0]   msg_addr_o
);
  logic        en_q, leg_q;
  logic [63:0] cnt;
  logic [31:0] ch_cfg  [N_CH];
  logic [63:0] ch_cmp  [N_CH];
  logic [31:0] ch_rdat [N_CH];
  logic [31:0] ch_radr [N_CH];
  logic [N_CH-1:0] sts, line;
  logic [4:0]  blk;

  assign blk = addr_i[7:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_i && addr_i == REG_GCFG) begin
      en_q  <= wdata_i[0];
      leg_q <= wdata_i[1];
    end
  end

  evt_main_cnt #(.HALF_W(32)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .wr_lo_i (wr_i && addr_i == REG_CLO),
    .wr_hi_i (wr_i && addr_i == REG_CHI),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    evt_channel #(.CMP_DLY(CMP_DLY), .PER_CAP(PER_CAP[c])) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .cnt_run_i  (en_q),
      .wr_i       (wr_i && blk == 5'(c + 1)),
      .reg_i      (addr_i[2:0]),
      .wdata_i    (wdata_i),
      .sts_clr_i  (wr_i && addr_i == REG_STS && wdata_i[c]),
      .cfg_o      (ch_cfg[c]),
      .cmp_o      (ch_cmp[c]),
      .rdat_o     (ch_rdat[c]),
      .radr_o     (ch_radr[c]),
      .sts_o      (sts[c]),
      .irq_line_o (line[c]),
      .msg_stb_o  (msg_stb_o[c])
    );
    assign msg_data_o[c*32 +: 32] = ch_rdat[c];
    assign msg_addr_o[c*32 +: 32] = ch_radr[c];
    if (c < 2) begin : g_leg
      assign irq_o[c]     = line[c] && !leg_q;
      assign leg_irq_o[c] = line[c] && leg_q;
    end else begin : g_std
      assign irq_o[c] = line[c];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_ID:   rdata_o = {16'd0, 1'b1, 2'b00, 5'(N_CH - 1), 8'd0};
      REG_PER:  rdata_o = PERIOD_FS;
      REG_GCFG: rdata_o = {30'd0, leg_q, en_q};
      REG_STS:  rdata_o = 32'(sts);
      REG_CLO:  rdata_o = cnt[31:0];
      REG_CHI:  rdata_o = cnt[63:32];
      default: ;
    endcase
    for (int c = 0; c < N_CH; c++) begin
      if (blk == 5'(c + 1)) begin
        case (addr_i[2:0])
          CH_CFG:  rdata_o = ch_cfg[c];
          CH_CMPL: rdata_o = ch_cmp[c][31:0];
          CH_CMPH: rdata_o = ch_cmp[c][63:32];
          CH_RDAT: rdata_o = ch_rdat[c];
          CH_RADR: rdata_o = ch_radr[c];
          default: ;
        endcase
      end
    end
  end

  AST_LEG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q |-> irq_o[1:0] == 2'b00); // R10
  AST_STS_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_STS && wdata_i[0] && !en_q) |=> !sts[0]); // R8
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int N = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [7:0]    addr_i = 8'h0;
  logic [31:0]   wdata_i = 32'h0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  irq_o, msg_stb_o;
  logic [1:0]    leg_irq_o;
  logic [N*32-1:0] msg_data_o, msg_addr_o;

  int n_chk = 0, n_bad = 0;

  evt_timer u_evt_timer (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .irq_o, .leg_irq_o, .msg_stb_o, .msg_data_o, .msg_addr_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b1, 8'h00, 32'h0000_8200, 4'd1},
    '{1'b1, 8'h01, 32'h0098_9680, 4'd1},
    '{1'b0, 8'h04, 32'h0000_1234, 4'd4},
    '{1'b0, 8'h05, 32'h0000_0005, 4'd4},
    '{1'b1, 8'h04, 32'h0000_1234, 4'd4},
    '{1'b1, 8'h05, 32'h0000_0005, 4'd4},
    '{1'b1, 8'h08, 32'h0000_0110, 4'd12},
    '{1'b1, 8'h10, 32'h0000_0100, 4'd12},
    '{1'b0, 8'h10, 32'h0000_000E, 4'd12},
    '{1'b1, 8'h10, 32'h0000_0106, 4'd12},
    '{1'b0, 8'h10, 32'h0000_0000, 4'd12},
    '{1'b0, 8'h0B, 32'hCAFE_0001, 4'd9},
    '{1'b1, 8'h0B, 32'hCAFE_0001, 4'd9},
    '{1'b1, 8'h1A, 32'hFFFF_FFFF, 4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  int          pc_irq [N];
  int          pc_msg [N];
  int          pc_leg [2];
  logic [31:0] f_irq [N];
  logic [31:0] f_msg [N];
  logic [31:0] f_leg [2];
  logic [31:0] seq0 [4];
  logic [31:0] mdat0, madr0;

  task automatic watch(input int ncyc);
    for (int c = 0; c < N; c++) begin pc_irq[c] = 0; pc_msg[c] = 0; f_irq[c] = 0; f_msg[c] = 0; end
    for (int c = 0; c < 2; c++) begin pc_leg[c] = 0; f_leg[c] = 0; end
    for (int k = 0; k < 4; k++) seq0[k] = 0;
    addr_i = 8'h04;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk_i);
      #1;
      for (int c = 0; c < N; c++) begin
        if (irq_o[c]) begin
          if (pc_irq[c] == 0) f_irq[c] = rdata_o;
          if (c == 0 && pc_irq[0] < 4) seq0[pc_irq[0]] = rdata_o;
          pc_irq[c]++;
        end
        if (msg_stb_o[c]) begin
          if (pc_msg[c] == 0) f_msg[c] = rdata_o;
          if (c == 0) begin mdat0 = msg_data_o[31:0]; madr0 = msg_addr_o[31:0]; end
          pc_msg[c]++;
        end
      end
      for (int c = 0; c < 2; c++) if (leg_irq_o[c]) begin
        if (pc_leg[c] == 0) f_leg[c] = rdata_o;
        pc_leg[c]++;
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R2 reset state
    rd(8'h02, v); chk("R2 gcfg", v, 32'h0);
    rd(8'h03, v); chk("R2 status", v, 32'h0);
    rd(8'h04, v); chk("R2 counter", v, 32'h0);
    chk("R2 irq", 32'(irq_o), 32'h0);

    foreach (VEC[i]) begin
      if (VEC[i].rd) begin
        rd(VEC[i].addr, v);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].data);
      end else begin
        wr(VEC[i].addr, VEC[i].data);
      end
    end

    // R5 one-shot exact match, passed value never fires; R8 pulse timing
    wr(8'h04, 32'h40); wr(8'h05, 32'h0);
    wr(8'h08, 32'h4); wr(8'h0A, 32'h0); wr(8'h09, 32'h50);
    wr(8'h10, 32'h4); wr(8'h12, 32'h0); wr(8'h11, 32'h10);
    idle(3);
    wr(8'h02, 32'h1);
    watch(40);
    wr(8'h02, 32'h0);
    chk("R5 one-shot count", pc_irq[0], 1);
    chk("R8 pulse counter", f_irq[0], 32'h51);
    chk("R5 passed cmp silent", pc_irq[1], 0);
    // R3 frozen counter
    rd(8'h04, v); idle(5); rd(8'h04, v2);
    chk("R3 frozen", v2, v);
    wr(8'h08, 32'h0); wr(8'h10, 32'h0);

    // R6 periodic set-value sequence
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h4C); wr(8'h0A, 32'h0); wr(8'h09, 32'h20);
    wr(8'h09, 32'h10); wr(8'h0A, 32'h0);
    idle(3);
    rd(8'h08, v); chk("R6 setval cleared", v, 32'h11C);
    wr(8'h02, 32'h1);
    watch(70);
    wr(8'h02, 32'h0);
    chk("R6 pulse count", pc_irq[0], 3);
    chk("R6 hit1", seq0[0], 32'h21);
    chk("R6 hit2", seq0[1], 32'h31);
    chk("R6 hit3", seq0[2], 32'h41);
    rd(8'h09, v); chk("R6 reloaded cmp", v, 32'h50);
    wr(8'h08, 32'h0);

    // R11 comparator write delay
    wr(8'h19, 32'h77);
    rd(8'h19, v); chk("R11 edge+0 old", v, 32'hFFFF_FFFF);
    idle(1); rd(8'h19, v); chk("R11 edge+1 old", v, 32'hFFFF_FFFF);
    idle(1); rd(8'h19, v); chk("R11 edge+2 new", v, 32'h77);

    // R8 level, sticky status, enable gate, write-one-to-clear
    wr(8'h04, 32'h100);
    wr(8'h1A, 32'h0); wr(8'h19, 32'h105); wr(8'h18, 32'h6);
    idle(3);
    wr(8'h02, 32'h1); idle(12); wr(8'h02, 32'h0);
    chk("R8 level high", 32'(irq_o[2]), 32'h1);
    rd(8'h03, v); chk("R8 status set", v, 32'h4);
    wr(8'h18, 32'h2);
    chk("R8 gated low", 32'(irq_o[2]), 32'h0);
    rd(8'h03, v); chk("R8 status kept", v, 32'h4);
    wr(8'h18, 32'h6);
    chk("R8 regated high", 32'(irq_o[2]), 32'h1);
    wr(8'h03, 32'h4);
    chk("R8 cleared line", 32'(irq_o[2]), 32'h0);
    rd(8'h03, v); chk("R8 cleared status", v, 32'h0);

    // R7 32-bit compare vs 64-bit control channel
    wr(8'h04, 32'h10); wr(8'h05, 32'h1);
    wr(8'h18, 32'h24); wr(8'h19, 32'h18);
    wr(8'h10, 32'h4); wr(8'h11, 32'h18);
    idle(3);
    wr(8'h02, 32'h1);
    watch(20);
    wr(8'h02, 32'h0);
    chk("R7 m32 fires", pc_irq[2], 1);
    chk("R7 m32 timing", f_irq[2], 32'h19);
    chk("R7 64-bit silent", pc_irq[1], 0);
    wr(8'h18, 32'h0); wr(8'h10, 32'h0);

    // R9 message strobe
    wr(8'h04, 32'h0); wr(8'h05, 32'h0);
    wr(8'h0C, 32'hFEE0_0000);
    wr(8'h08, 32'h84); wr(8'h09, 32'h8);
    idle(3);
    wr(8'h02, 32'h1);
    watch(20);
    wr(8'h02, 32'h0);
    chk("R9 strobe count", pc_msg[0], 1);
    chk("R9 strobe timing", f_msg[0], 32'h9);
    chk("R9 irq silent", pc_irq[0], 0);
    chk("R9 data word", mdat0, 32'hCAFE_0001);
    chk("R9 addr word", madr0, 32'hFEE0_0000);

    // R10 legacy routing
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h4); wr(8'h09, 32'h6);
    wr(8'h10, 32'h4); wr(8'h12, 32'h0); wr(8'h11, 32'h9);
    idle(3);
    wr(8'h02, 32'h3);
    watch(20);
    wr(8'h02, 32'h0);
    chk("R10 leg0", pc_leg[0], 1);
    chk("R10 leg1", pc_leg[1], 1);
    chk("R10 leg1 timing", f_leg[1], 32'hA);
    chk("R10 irq0 quiet", pc_irq[0], 0);
    chk("R10 irq1 quiet", pc_irq[1], 0);

    // R1 read-only words ignore writes
    wr(8'h01, 32'h1);
    rd(8'h01, v); chk("R1 period read-only", v, 32'h0098_9680);

    finish_run();
  end
endmodule